// File: doc/BRIEF.md
# Direct Page Effective Address Generator

This unit forms the 24-bit operand address for direct-page and direct-page-indexed fetches in a 16-bit processor that can also run in an 8-bit emulation mode. It adds the 16-bit direct base, an 8-bit operand offset and, when the mode select asks for one, the X or Y index register. The result is registered and presented one clock after a valid strobe, together with a valid flag. The result always lies in bank 0.

The emulation flag only changes how the sum wraps; it never changes latency. In emulation mode the address stays inside one 256-byte page only when the low byte of the base is zero. With any other low byte the sum carries freely through bank 0. A further output marks a nonzero base low byte, so that an outside sequencer can insert a penalty cycle. That flag does not alter this unit's own timing.

Top module: `dp_addr_gen`

## Requirements
- R1: The upper address byte `ea[23:16]` is always 0x00 whenever `out_valid` is 1.
- R2: In native mode (`emu`=0) the low 16 bits of the address are `dir + offset + index` with no page wrap. Example: dir=0x1080, offset=0xF0, X=0x0F, mode X gives 0x00117F.
- R3: With `emu`=1 and `dir[7:0]`=0x00, `ea[15:8]` equals `dir[15:8]` and `ea[7:0]` is `(offset + index) mod 256`.
- R4: With `emu`=1 and `dir[7:0]` nonzero, the address is `dir + offset + index` mod 65536, with no page wrap.
- R5: When `idx_narrow`=1 or `emu`=1, only the low 8 bits of the selected index are added. Otherwise all 16 bits are added.
- R6: The mode code `mode[1:0]` selects the index: 00 adds none, 01 adds X, 10 adds Y, and 11 adds none.
- R7: A carry out of bit 15 of the sum is dropped. For example, dir=0xFFF0 with offset 0x20 in native mode gives 0x000010.
- R8: `out_valid` is 1 exactly one clock after a cycle with `in_valid`=1, and 0 after a cycle with `in_valid`=0. The latency is the same in both modes. Reset clears `out_valid`.
- R9: `dl_nonzero` is registered with the address. It is 1 when the `dir[7:0]` sampled with the strobe was nonzero.
- R10: In a cycle with `in_valid`=0, `ea` and `dl_nonzero` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands valid this cycle |
| dir | input | 16 | Direct page base register |
| offset | input | 8 | Operand offset byte |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| emu | input | 1 | Emulation mode flag |
| idx_narrow | input | 1 | Index width flag; 1 selects 8-bit index |
| mode | input | 2 | Index select code (00 none, 01 X, 10 Y, 11 none) |
| out_valid | output | 1 | Registered address valid |
| ea | output | 24 | Registered effective address |
| dl_nonzero | output | 1 | Registered flag: base low byte was nonzero |

## Verification
A wrong wrap decision or a wrong index selection shows as a wrong `ea` on the very next clock, because there is only one register stage. Errors in the page-wrap path only appear for an emulation-mode base with a zero low byte and an offset-plus-index sum above 0xFF. For that reason the directed cases aim at exactly that carry and at the bit-15 carry. A stuck or leaky enable shows as `ea` changing during idle cycles, or as `out_valid` failing to follow the strobe by one cycle.

// File: rtl/dp_addr_pkg.sv
package dp_addr_pkg;
  localparam int unsigned DP_W   = 16;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned BANK_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_X    = 2'b01,
    SEL_Y    = 2'b10,
    SEL_RSVD = 2'b11
  } idx_sel_e;
endpackage

// File: rtl/dp_index_sel.sv
module dp_index_sel #(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          narrow_i,
  output logic [DW-1:0] idx_o
);
  import dp_addr_pkg::*;

  logic [DW-1:0] raw;

  always_comb begin
    unique case (idx_sel_e'(mode_i))
      SEL_X:   raw = x_i;
      SEL_Y:   raw = y_i;
      default: raw = '0;
    endcase
  end

  generate
    if (DW > NW) begin : g_mask
      always_comb begin
        idx_o = raw;
        if (narrow_i) idx_o[DW-1:NW] = '0;
      end
    end else begin : g_pass
      always_comb idx_o = raw;
    end
  endgenerate

  always_comb begin
    if (narrow_i) begin
      AST_NARROW_HIGH_ZERO: assert (idx_o[DW-1:NW] == '0); // R5
    end
  end
endmodule

// File: rtl/dp_page_adder.sv
module dp_page_adder #(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 8
) (
  input  logic [DW-1:0] dir_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [DW-1:0] idx_i,
  input  logic          emu_i,
  output logic [DW-1:0] sum_o,
  output logic          dl_nz_o
);
  logic [DW-1:0] full_sum;
  logic [OW-1:0] page_sum;
  logic          page_mode;

  always_comb begin
    dl_nz_o   = (dir_i[OW-1:0] != '0);
    full_sum  = dir_i + DW'(ofs_i) + idx_i;
    page_sum  = ofs_i + idx_i[OW-1:0];
    page_mode = emu_i && !dl_nz_o;
    if (page_mode) sum_o = {dir_i[DW-1:OW], page_sum};
    else           sum_o = full_sum;
  end
endmodule

// File: rtl/dp_addr_gen.sv
module dp_addr_gen
  import dp_addr_pkg::*;
#(
  parameter int unsigned DW = DP_W,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned BW = BANK_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  dir,
  input  logic [OW-1:0]  offset,
  input  logic [DW-1:0]  idx_x,
  input  logic [DW-1:0]  idx_y,
  input  logic           emu,
  input  logic           idx_narrow,
  input  logic [1:0]     mode,
  output logic           out_valid,
  output logic [BW+DW-1:0] ea,
  output logic           dl_nonzero
);
  localparam int unsigned AW = BW + DW;

  logic          narrow_eff;
  logic [DW-1:0] idx_val;
  logic [DW-1:0] sum;
  logic          dl_nz;

  logic          vld_d, vld_q;
  logic [AW-1:0] ea_d, ea_q;
  logic          flg_d, flg_q;

  assign narrow_eff = idx_narrow | emu;

  dp_index_sel #(.DW(DW), .NW(OW)) u_idx (
    .mode_i   (mode),
    .x_i      (idx_x),
    .y_i      (idx_y),
    .narrow_i (narrow_eff),
    .idx_o    (idx_val)
  );

  dp_page_adder #(.DW(DW), .OW(OW)) u_add (
    .dir_i   (dir),
    .ofs_i   (offset),
    .idx_i   (idx_val),
    .emu_i   (emu),
    .sum_o   (sum),
    .dl_nz_o (dl_nz)
  );

  always_comb begin
    vld_d = in_valid;
    ea_d  = ea_q;
    flg_d = flg_q;
    if (in_valid) begin
      ea_d  = {{BW{1'b0}}, sum};
      flg_d = dl_nz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ea_q  <= '0;
      flg_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ea_q  <= ea_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid  = vld_q;
  assign ea         = ea_q;
  assign dl_nonzero = flg_q;

  AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ea[AW-1:DW] == '0); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(dl_nonzero))); // R10
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && emu && dir[OW-1:0] == '0) |=> ea[DW-1:OW] == $past(dir[DW-1:OW])); // R3
  AST_DL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dl_nonzero == ($past(dir[OW-1:0]) != '0)); // R9
endmodule

// File: tb/test_dp_addr_gen.sv
module test_dp_addr_gen;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] dir;
  logic [7:0]  offset;
  logic [15:0] idx_x;
  logic [15:0] idx_y;
  logic        emu;
  logic        idx_narrow;
  logic [1:0]  mode;
  logic        out_valid;
  logic [23:0] ea;
  logic        dl_nonzero;

  int checks = 0;
  int fails  = 0;

  dp_addr_gen i_dp_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir), .offset(offset),
    .idx_x(idx_x), .idx_y(idx_y), .emu(emu), .idx_narrow(idx_narrow), .mode(mode),
    .out_valid(out_valid), .ea(ea), .dl_nonzero(dl_nonzero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [23:0] model_ea(input logic [15:0] d, input logic [7:0] o,
      input logic [15:0] x, input logic [15:0] y, input logic e, input logic n,
      input logic [1:0] m);
    logic [15:0] ix;
    logic [15:0] s;
    logic [7:0]  lo;
    ix = (m == 2'b01) ? x : (m == 2'b10) ? y : 16'h0000;
    if (e || n) ix = {8'h00, ix[7:0]};
    s = d + {8'h00, o} + ix;
    if (e && d[7:0] == 8'h00) begin
      lo = o + ix[7:0];
      s  = {d[15:8], lo};
    end
    return {8'h00, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] d, input logic [7:0] o,
      input logic [15:0] x, input logic [15:0] y, input logic e, input logic n,
      input logic [1:0] m);
    logic [23:0] exp;
    exp = model_ea(d, o, x, y, e, n, m);
    dir = d; offset = o; idx_x = x; idx_y = y; emu = e; idx_narrow = n; mode = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    chk(req, {8'h00, ea}, {8'h00, exp});
    chk({req, " R9 flag"}, {31'd0, dl_nonzero}, {31'd0, d[7:0] != 8'h00});
  endtask

  task automatic idle_check();
    logic [23:0] prev_ea;
    logic        prev_fl;
    prev_ea = ea; prev_fl = dl_nonzero;
    dir = 16'hABCD; offset = 8'h55; idx_x = 16'h1111; mode = 2'b01;
    @(negedge clk);
    chk("R8 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R10 hold ea", {8'h00, ea}, {8'h00, prev_ea});
    chk("R10 hold flag", {31'd0, dl_nonzero}, {31'd0, prev_fl});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0; in_valid = 1'b0; dir = '0; offset = '0; idx_x = '0; idx_y = '0;
    emu = 1'b0; idx_narrow = 1'b0; mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 post-reset idle", {31'd0, out_valid}, 32'd0);

    apply("R2 native example", 16'h1080, 8'hF0, 16'h000F, 16'h0000, 1'b0, 1'b0, 2'b01);
    chk("R2 literal", {8'h00, ea}, 32'h0000117F);
    apply("R4 emu dl nonzero", 16'h1080, 8'hF0, 16'h000F, 16'h0000, 1'b1, 1'b0, 2'b01);
    chk("R4 literal", {8'h00, ea}, 32'h0000117F);
    apply("R3 emu page wrap", 16'h1200, 8'hF0, 16'h0020, 16'h0000, 1'b1, 1'b0, 2'b01);
    chk("R3 literal", {8'h00, ea}, 32'h00001210);
    apply("R2 native no wrap", 16'h1200, 8'hF0, 16'h0020, 16'h0000, 1'b0, 1'b0, 2'b01);
    chk("R2 literal cross", {8'h00, ea}, 32'h00001310);
    apply("R7 carry drop", 16'hFFF0, 8'h20, 16'h0000, 16'h0000, 1'b0, 1'b0, 2'b00);
    chk("R7 literal", {8'h00, ea}, 32'h00000010);
    apply("R6 reserved code", 16'h0300, 8'h10, 16'h0044, 16'h0055, 1'b0, 1'b0, 2'b11);
    chk("R6 literal", {8'h00, ea}, 32'h00000310);
    apply("R6 Y select", 16'h0300, 8'h10, 16'h0044, 16'h0055, 1'b0, 1'b0, 2'b10);
    chk("R6 Y literal", {8'h00, ea}, 32'h00000365);
    apply("R5 narrow index", 16'h0100, 8'h01, 16'h1234, 16'h0000, 1'b0, 1'b1, 2'b01);
    chk("R5 literal", {8'h00, ea}, 32'h00000135);
    apply("R5 wide index", 16'h0100, 8'h01, 16'h1234, 16'h0000, 1'b0, 1'b0, 2'b01);
    chk("R5 wide literal", {8'h00, ea}, 32'h00001335);
    apply("R5 emu forces narrow", 16'h0101, 8'h01, 16'h1234, 16'h0000, 1'b1, 1'b0, 2'b01);
    chk("R5 emu literal", {8'h00, ea}, 32'h00000136);
    idle_check();

    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (($urandom % 4) == 0) d[7:0] = 8'h00;
      apply("R1 R2 R3 R4 random", d, 8'($urandom), 16'($urandom), 16'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom));
      chk("R1 bank", {24'h0, ea[23:16]}, 32'd0);
      if (($urandom % 5) == 0) idle_check();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule